// File: doc/BRIEF.md
# Ones' Complement End-Around-Carry Adder

This block adds two signed numbers held in ones' complement form and returns their ones' complement sum. A non-negative value is held as its plain binary magnitude with the top bit clear. A negative value is held as the bitwise inverse of its magnitude, so its top bit is set. With the default width of 16 the codes cover -32767 to +32767. Both the all-zeros code and the all-ones code mean zero, and the all-ones code is read as negative zero.

The block first makes a plain binary sum of the two codes. If that sum carries out of the top bit, the carry is dropped from the top and added back at the bottom as an increment. The result is therefore taken modulo 2^N - 1. The path is purely combinational. A flag reports when the result is the negative-zero code, and a second flag reports signed overflow.

Top module: `oc_eac_adder`

## Requirements
- R1: When neither the binary add of the two codes carries out nor the operands overflow, `sum_o` equals their plain binary sum (for example 16-bit 0x0003 + 0x0004 = 0x0007).
- R2: When the binary add carries out of bit WIDTH-1, the carry is discarded and `sum_o` equals the kept WIDTH bits plus one. Two negative operands always take this path (16-bit 0xFFFE + 0xFFFE = 0xFFFD, that is -1 + -1 = -2).
- R3: For operands of opposite sign, the correction is applied exactly when the true sum is positive (16-bit 5 + -3 gives 0x0002; 3 + -5 gives 0xFFFD with no correction).
- R4: Opposite-sign operands of equal magnitude give the all-ones code (negative zero), and the result is left at that value.
- R5: Only all-zeros plus all-zeros gives the all-zeros code. All-ones plus all-ones, and all-ones plus all-zeros in either order, give all-ones.
- R6: `neg_zero_o` is 1 exactly when `sum_o` is all ones.
- R7: `ovf_o` is 1 exactly when both operands have the same top bit and the top bit of `sum_o` differs from it. Operands of opposite sign never raise it (16-bit 0x7FFF + 0x0001 and 0x8000 + 0xFFFE both overflow).
- R8: Swapping the two operands changes none of the outputs.
- R9: The width is set by the parameter `WIDTH`. At WIDTH = 8, 0x7F + 0x81 gives 0x01 and 0x7F + 0x01 gives 0x80 with `ovf_o` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | WIDTH | First operand code |
| op_b_i | input | WIDTH | Second operand code |
| sum_o | output | WIDTH | Ones' complement sum code |
| neg_zero_o | output | 1 | Result is the all-ones (negative zero) code |
| ovf_o | output | 1 | Signed overflow |

## Verification
Every output depends only on the current operand values, so each result is due in the same cycle the operands are applied, with no register between them. The bench changes the operands just after a rising edge and reads all outputs at the following falling edge. This leaves half a period for the logic to settle and keeps every check away from the edge at which the stimulus changes.

// File: rtl/oc_eac_adder.sv
module oc_eac_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             neg_zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   raw_sum;
  logic             wrap_carry;
  logic [WIDTH-1:0] wrap_inc;

  assign raw_sum    = {1'b0, op_a_i} + {1'b0, op_b_i};
  assign wrap_carry = raw_sum[WIDTH];
  assign wrap_inc   = {{(WIDTH-1){1'b0}}, wrap_carry};

  // A carried raw sum keeps at most all-ones minus one, so this cannot carry again.
  assign sum_o      = raw_sum[WIDTH-1:0] + wrap_inc;
  assign neg_zero_o = &sum_o;
  assign ovf_o      = (op_a_i[MSB] == op_b_i[MSB]) && (sum_o[MSB] != op_a_i[MSB]);
endmodule

module oc_eac_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] op_a_i,
  input logic [WIDTH-1:0] op_b_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             neg_zero_o,
  input logic             ovf_o
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0] modulus;
  logic [WIDTH:0] in_total;
  logic [WIDTH:0] out_ext;

  assign modulus  = {1'b0, {WIDTH{1'b1}}};
  assign in_total = {1'b0, op_a_i} + {1'b0, op_b_i};
  assign out_ext  = {1'b0, sum_o};

  always_comb begin
    assert_mod_sum_R2: assert ((in_total % modulus) == (out_ext % modulus));
    assert_equal_mag_negzero_R4: assert (!(op_a_i == ~op_b_i) || neg_zero_o);
    assert_pos_zero_only_R5: assert (!(op_a_i == '0 && op_b_i == '0) || sum_o == '0);
    assert_no_zero_from_negzero_R5: assert (!(&op_a_i) || sum_o != '0);
    assert_no_overflow_R7: assert (op_a_i[MSB] == op_b_i[MSB] || !ovf_o);
  end
endmodule

bind oc_eac_adder oc_eac_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .op_a_i(op_a_i), .op_b_i(op_b_i), .sum_o(sum_o),
  .neg_zero_o(neg_zero_o), .ovf_o(ovf_o)
);

// File: tb/oc_eac_adder_tb_top.sv
module oc_eac_adder_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] a16, b16, s16;
  logic        nz16, ov16;
  logic [7:0]  a8, b8, s8;
  logic        nz8, ov8;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  oc_eac_adder #(.WIDTH(16)) dut_i (
    .op_a_i(a16), .op_b_i(b16), .sum_o(s16), .neg_zero_o(nz16), .ovf_o(ov16));
  oc_eac_adder #(.WIDTH(8)) dut8_i (
    .op_a_i(a8), .op_b_i(b8), .sum_o(s8), .neg_zero_o(nz8), .ovf_o(ov8));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apply16(logic [15:0] a, logic [15:0] b);
    @(posedge clk); #1;
    a16 = a; b16 = b;
    @(negedge clk);
  endtask

  task automatic expect16(string req, logic [15:0] s, logic nz, logic ov);
    check(req, {16'h0, s16}, {16'h0, s});
    check(req, {31'h0, nz16}, {31'h0, nz});
    check(req, {31'h0, ov16}, {31'h0, ov});
  endtask

  task automatic t_plain_add;
    apply16(16'h0003, 16'h0004); expect16("R1", 16'h0007, 1'b0, 1'b0);
    apply16(16'h1234, 16'h0101); expect16("R1", 16'h1335, 1'b0, 1'b0);
  endtask

  task automatic t_end_around;
    apply16(16'hFFFE, 16'hFFFE); expect16("R2", 16'hFFFD, 1'b0, 1'b0);
    apply16(16'hFFF0, 16'hFF00); expect16("R2", 16'hFEF1, 1'b0, 1'b0);
  endtask

  task automatic t_mixed_sign;
    apply16(16'h0005, 16'hFFFC); expect16("R3", 16'h0002, 1'b0, 1'b0);
    apply16(16'h0003, 16'hFFFA); expect16("R3", 16'hFFFD, 1'b0, 1'b0);
  endtask

  task automatic t_equal_mag;
    apply16(16'h0007, 16'hFFF8); expect16("R4", 16'hFFFF, 1'b1, 1'b0);
    apply16(16'h7FFF, 16'h8000); expect16("R4", 16'hFFFF, 1'b1, 1'b0);
  endtask

  task automatic t_zero_rules;
    apply16(16'h0000, 16'h0000); expect16("R5", 16'h0000, 1'b0, 1'b0);
    apply16(16'hFFFF, 16'hFFFF); expect16("R5", 16'hFFFF, 1'b1, 1'b0);
    apply16(16'hFFFF, 16'h0000); expect16("R5", 16'hFFFF, 1'b1, 1'b0);
    apply16(16'h0000, 16'hFFFF); expect16("R5", 16'hFFFF, 1'b1, 1'b0);
  endtask

  task automatic t_negzero_flag;
    apply16(16'hFFFF, 16'h0001); expect16("R6", 16'h0001, 1'b0, 1'b0);
    apply16(16'h8000, 16'h7FFE); expect16("R6", 16'hFFFE, 1'b0, 1'b0);
  endtask

  task automatic t_overflow;
    apply16(16'h7FFF, 16'h0001); expect16("R7", 16'h8000, 1'b0, 1'b1);
    apply16(16'h8000, 16'hFFFE); expect16("R7", 16'h7FFF, 1'b0, 1'b1);
    apply16(16'h4000, 16'h3FFF); expect16("R7", 16'h7FFF, 1'b0, 1'b0);
  endtask

  task automatic t_swap;
    apply16(16'hFFFA, 16'h0003); expect16("R8", 16'hFFFD, 1'b0, 1'b0);
    apply16(16'h0001, 16'h7FFF); expect16("R8", 16'h8000, 1'b0, 1'b1);
  endtask

  task automatic t_width8;
    @(posedge clk); #1; a8 = 8'h7F; b8 = 8'h81; @(negedge clk);
    check("R9", {24'h0, s8}, 32'h01);
    check("R9", {31'h0, ov8}, 32'h0);
    @(posedge clk); #1; a8 = 8'h7F; b8 = 8'h01; @(negedge clk);
    check("R9", {24'h0, s8}, 32'h80);
    check("R9", {31'h0, ov8}, 32'h1);
    @(posedge clk); #1; a8 = 8'h0F; b8 = 8'hF0; @(negedge clk);
    check("R9", {31'h0, nz8}, 32'h1);
  endtask

  initial begin
    a16 = '0; b16 = '0; a8 = '0; b8 = '0;
    @(negedge clk);
    check("R5", {16'h0, s16}, 32'h0);
    check("R6", {31'h0, nz16}, 32'h0);
    t_plain_add();
    t_end_around();
    t_mixed_sign();
    t_equal_mag();
    t_zero_rules();
    t_negzero_flag();
    t_overflow();
    t_swap();
    t_width8();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule